// File: doc/BRIEF.md
# Management-Bus (MDIO) Master with Register Interface

This block lets software reach Ethernet PHY registers over the two-wire management bus. A simple register port exposes a mode register, a target register (PHY address plus register or device number), a 16-bit outgoing data register, a 16-bit captured data register and a command register. A write to the command register with its go bit set launches exactly one 64-bit management frame. The frame is shifted out on MDIO against an MDC clock that is divided down from the system clock. On read frames the master lets go of the line and samples the PHY's reply into the captured data register.

A mode bit selects between the two framing variants. The classic variant uses command codes for read and write. The extended variant uses separate command codes for the address cycle, the write and the read, and it takes the 16-bit register address of an address cycle from the outgoing data register. An extended access therefore takes two commands, and software polls the busy flag between them. MDIO is presented as a separate output, output-enable and input, so the pad can be a tri-state buffer.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register offsets are 0x40 mode (all 32 bits kept; bit 8 chooses the framing), 0x44 target (bits 12:8 PHY address, bits 4:0 register or device number, all other bits read 0), 0x48 outgoing data (bits 15:0 kept, upper bits read 0), 0x4C captured data (read only) and 0x50 command (bit 31 reads busy). Read data appears on reg_rdata one clock after reg_rd_en.
- R2: After reset every register reads 0, busy reads 0, and MDC and the MDIO output enable are low.
- R3: A command write with bit 8 set and a supported code in bits 1:0 starts a frame. Busy reads 1 from that write until the final MDC falling edge of the frame.
- R4: A frame is 64 bits sent MSB first: 32 ones, a 2-bit start field, a 2-bit opcode, 5 PHY address bits, 5 register or device bits, 2 turnaround bits and 16 data bits.
- R5: With mode bit 8 at 0, the start field is 01. Code 0 is a read with opcode 10 and code 1 is a write with opcode 01.
- R6: With mode bit 8 at 1, the start field is 00. Code 0 is an address cycle with opcode 00, code 1 is a write with opcode 01 and code 2 is a read with opcode 11.
- R7: Write and address frames drive all 64 bits, with turnaround 10 and the outgoing data register as the 16 data bits.
- R8: On read frames MDIO is released from bit 46 (turnaround) through bit 63. The 16 data bits are sampled on MDC rising edges into captured-data bits 15:0, and the upper bits read 0.
- R9: The captured data register changes only when a read frame completes.
- R10: A start request that arrives while busy is ignored. The running frame is unchanged and no further frame follows.
- R11: A command write without bit 8 set, or with an unsupported code (2 or 3 in classic mode, 3 in extended mode), starts nothing.
- R12: The MDC period is 2*MDC_HALF system clocks and MDC stays low while idle. MDIO changes only at MDC falling edges, so it is stable at every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | BUS_W | Register write data |
| reg_rdata | output | BUS_W | Registered read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe_o | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The bench models a PHY that records every bit and enable level at MDC rising edges and plays back a reply word. Each captured frame is compared with one built from the field rules, for every code in both framings. A wrong opcode or start field, or a swapped address field, makes that comparison fail. Releasing the line one bit late, or sampling on the wrong edge, shows up as a wrong enable pattern or shifted read data. The bench also issues a second start in mid-frame and issues unsupported codes. A design that restarts or queues the second start produces a frame mismatch or extra MDC edges. A design that decodes loosely starts a frame it should not.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int FIELD_W    = 5;
  localparam int WORD_W     = 16;

  localparam logic [7:0] OFS_MODE  = 8'h40;
  localparam logic [7:0] OFS_TGT   = 8'h44;
  localparam logic [7:0] OFS_WDATA = 8'h48;
  localparam logic [7:0] OFS_RDATA = 8'h4C;
  localparam logic [7:0] OFS_CMD   = 8'h50;

  localparam int MODE_SEL_BIT = 8;
  localparam int CMD_GO_BIT   = 8;
  localparam int CMD_BUSY_BIT = 31;

  typedef struct packed {
    logic                  ok;
    logic                  is_read;
    logic [FRAME_BITS-1:0] bits;
  } frame_req_t;
endpackage

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_pkg::*;
(
  input  logic               ext_mode,
  input  logic [1:0]         code,
  input  logic [FIELD_W-1:0] phy,
  input  logic [FIELD_W-1:0] regdev,
  input  logic [WORD_W-1:0]  wdata,
  output frame_req_t         req
);
  logic [1:0] st, op, ta;
  logic       rd, ok;
  logic [WORD_W-1:0] dat;

  always_comb begin
    st = ext_mode ? 2'b00 : 2'b01;
    op = 2'b00;
    rd = 1'b0;
    ok = 1'b1;
    if (!ext_mode) begin
      case (code)
        2'd0:    begin op = 2'b10; rd = 1'b1; end
        2'd1:    op = 2'b01;
        default: ok = 1'b0;
      endcase
    end else begin
      case (code)
        2'd0:    op = 2'b00;
        2'd1:    op = 2'b01;
        2'd2:    begin op = 2'b11; rd = 1'b1; end
        default: ok = 1'b0;
      endcase
    end
    ta  = rd ? 2'b11 : 2'b10;
    dat = rd ? {WORD_W{1'b1}} : wdata;
    req.ok      = ok;
    req.is_read = rd;
    req.bits    = {32'hFFFF_FFFF, st, op, phy, regdev, ta, dat};
  end
endmodule

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int MDC_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  frame_req_t        req,
  input  logic              tick,
  input  logic              mdi,
  output logic              busy,
  output logic              mdc,
  output logic              mdo,
  output logic              oe,
  output logic              rd_done,
  output logic [WORD_W-1:0] rd_value
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] DAT_IDX  = CNT_W'(DATA_POS);

  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  rd_q;
  logic [CNT_W-1:0]      nidx;

  assign nidx = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      mdc      <= 1'b0;
      mdo      <= 1'b0;
      oe       <= 1'b0;
      rd_done  <= 1'b0;
      rd_q     <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      rd_value <= '0;
    end else begin
      rd_done <= 1'b0;
      if (!busy) begin
        if (start && req.ok) begin
          busy  <= 1'b1;
          mdc   <= 1'b0;
          cnt_q <= '0;
          sh_q  <= req.bits;
          mdo   <= req.bits[FRAME_BITS-1];
          oe    <= 1'b1;
          rd_q  <= req.is_read;
        end
      end else if (tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
          if (rd_q && cnt_q >= DAT_IDX) rd_value <= {rd_value[WORD_W-2:0], mdi};
        end else begin
          mdc <= 1'b0;
          if (cnt_q == LAST_IDX) begin
            busy    <= 1'b0;
            oe      <= 1'b0;
            mdo     <= 1'b0;
            rd_done <= rd_q;
          end else begin
            cnt_q <= nidx;
            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
            mdo   <= sh_q[FRAME_BITS-2];
            oe    <= !(rd_q && nidx >= TA_IDX);
          end
        end
      end
    end
  end

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !oe));
  p_mdo_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (busy && $rose(mdc)) |-> $stable(mdo));
  p_ignore_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(rd_q));
  p_read_release_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && cnt_q >= TA_IDX) |-> !oe);
  p_write_drive_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_q) |-> oe);
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [WORD_W-1:0] rd_value,
  output logic              ext_mode,
  output logic [FIELD_W-1:0] phy,
  output logic [FIELD_W-1:0] regdev,
  output logic [WORD_W-1:0] out_word,
  output logic              start,
  output logic [1:0]        code
);
  logic [BUS_W-1:0]   mode_q;
  logic [FIELD_W-1:0] phy_q, regdev_q;
  logic [WORD_W-1:0]  wd_q, cap_q;
  logic               hit_cmd;

  assign hit_cmd  = wr_en && (addr == ADDR_W'(OFS_CMD));
  assign start    = hit_cmd && wdata[CMD_GO_BIT];
  assign code     = wdata[1:0];
  assign ext_mode = mode_q[MODE_SEL_BIT];
  assign phy      = phy_q;
  assign regdev   = regdev_q;
  assign out_word = wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      phy_q    <= '0;
      regdev_q <= '0;
      wd_q     <= '0;
      cap_q    <= '0;
      rdata    <= '0;
    end else begin
      if (wr_en) begin
        if (addr == ADDR_W'(OFS_MODE))  mode_q <= wdata;
        if (addr == ADDR_W'(OFS_TGT)) begin
          phy_q    <= wdata[12:8];
          regdev_q <= wdata[4:0];
        end
        if (addr == ADDR_W'(OFS_WDATA)) wd_q <= wdata[WORD_W-1:0];
      end
      if (rd_done) cap_q <= rd_value;
      if (rd_en) begin
        rdata <= '0;
        if (addr == ADDR_W'(OFS_MODE))  rdata <= mode_q;
        if (addr == ADDR_W'(OFS_TGT))   rdata <= BUS_W'({phy_q, 3'b000, regdev_q});
        if (addr == ADDR_W'(OFS_WDATA)) rdata <= BUS_W'(wd_q);
        if (addr == ADDR_W'(OFS_RDATA)) rdata <= BUS_W'(cap_q);
        if (addr == ADDR_W'(OFS_CMD))   rdata[CMD_BUSY_BIT] <= busy;
      end
    end
  end

  p_capture_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_done |=> $stable(cap_q));
  p_mode_keep_r1: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(OFS_MODE)) |=> $stable(mode_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BUS_W    = 32,
  parameter int MDC_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic               ext_mode, start, busy, tick, rd_done;
  logic [1:0]         code;
  logic [FIELD_W-1:0] phy, regdev;
  logic [WORD_W-1:0]  out_word, rd_value;
  frame_req_t         req;

  mdio_reg_bank #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .busy(busy), .rd_done(rd_done), .rd_value(rd_value),
    .ext_mode(ext_mode), .phy(phy), .regdev(regdev), .out_word(out_word),
    .start(start), .code(code)
  );

  mdio_frame_build u_build (
    .ext_mode(ext_mode), .code(code), .phy(phy), .regdev(regdev),
    .wdata(out_word), .req(req)
  );

  mdio_mdc_div #(.MDC_HALF(MDC_HALF)) u_div (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  mdio_shift_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .req(req), .tick(tick),
    .mdi(mdio_i), .busy(busy), .mdc(mdc_o), .mdo(mdio_o), .oe(mdio_oe_o),
    .rd_done(rd_done), .rd_value(rd_value)
  );
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc_o, mdio_o, mdio_oe_o, mdio_i;

  int checks = 0, errors = 0;
  int rcount = 0;
  int pmin, pmax;
  time last_rise;
  logic [63:0] cap, capoe, resp_word;

  always #5 clk = ~clk;

  mdio_mgmt_master #(.ADDR_W(8), .BUS_W(32), .MDC_HALF(HALF)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  assign mdio_i = (rcount < 64) ? resp_word[63 - rcount] : 1'b1;

  always @(posedge mdc_o) begin
    if (rcount < 64) begin
      cap[63 - rcount]   = mdio_o;
      capoe[63 - rcount] = mdio_oe_o;
    end
    if (rcount > 0) begin
      if (int'(($time - last_rise) / 10) < pmin) pmin = int'(($time - last_rise) / 10);
      if (int'(($time - last_rise) / 10) > pmax) pmax = int'(($time - last_rise) / 10);
    end
    last_rise = $time;
    rcount++;
  end

  // watchdog
  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000", wd_cnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd_en = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h50, v);
      if (!v[31]) break;
    end
  endtask

  task automatic arm();
    rcount = 0; cap = '0; capoe = '0; pmin = 1000; pmax = 0;
  endtask

  function automatic logic [63:0] exp_frame(input bit ext, input logic [1:0] c,
      input logic [4:0] p, input logic [4:0] r, input logic [15:0] w);
    logic [1:0] st, op; bit rdf;
    st = ext ? 2'b00 : 2'b01;
    if (!ext) begin op = (c == 0) ? 2'b10 : 2'b01; rdf = (c == 0); end
    else begin op = (c == 0) ? 2'b00 : (c == 1) ? 2'b01 : 2'b11; rdf = (c == 2); end
    return {32'hFFFF_FFFF, st, op, p, r, (rdf ? 2'b11 : 2'b10), (rdf ? 16'hFFFF : w)};
  endfunction

  // {ext, code, phy, reg/dev, out word, phy reply}
  localparam logic [44:0] VEC [6] = '{
    {1'b0, 2'd1, 5'h01, 5'h00, 16'h1140, 16'h0000},
    {1'b0, 2'd0, 5'h1F, 5'h02, 16'h0000, 16'h004D},
    {1'b1, 2'd0, 5'h03, 5'h01, 16'h0007, 16'h0000},
    {1'b1, 2'd1, 5'h03, 5'h01, 16'hA5A5, 16'h0000},
    {1'b1, 2'd2, 5'h10, 5'h1E, 16'h0000, 16'h8001},
    {1'b0, 2'd0, 5'h00, 5'h1F, 16'h0000, 16'h5A3C}
  };

  localparam logic [63:0] RD_MASK = 64'hFFFF_FFFF_FFFC_0000;

  initial begin
    logic [31:0] v;
    logic [15:0] last_rd;
    logic [63:0] ef;
    resp_word = '1;
    arm();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    chk(!mdc_o && !mdio_oe_o, "R2 idle pins", {62'b0, mdc_o, mdio_oe_o}, 64'h0);
    rd(8'h40, v); chk(v == 0, "R2 mode reset", 64'(v), 64'h0);
    rd(8'h4C, v); chk(v == 0, "R2 capture reset", 64'(v), 64'h0);
    rd(8'h50, v); chk(v == 0, "R2 busy reset", 64'(v), 64'h0);

    // R1: readback masking
    wr(8'h48, 32'hFFFF_1234); rd(8'h48, v); chk(v == 32'h1234, "R1 wdata width", 64'(v), 64'h1234);
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, v); chk(v == 32'h1F1F, "R1 target fields", 64'(v), 64'h1F1F);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, v); chk(v == 32'hFFFF_FFFF, "R1 mode kept", 64'(v), 64'hFFFF_FFFF);

    last_rd = 16'h0;
    for (int k = 0; k < 6; k++) begin
      logic [44:0] e;
      bit isr;
      logic [31:0] mv;
      e = VEC[k];
      isr = (!e[44] && e[43:42] == 0) || (e[44] && e[43:42] == 2);
      mv = 32'h0010_00A0 | (32'(e[44]) << 8);
      wr(8'h40, mv);
      wr(8'h44, {19'h0, e[41:37], 3'b000, e[36:32]});
      wr(8'h48, {16'h0, e[31:16]});
      resp_word = {48'hFFFF_FFFF_FFFF, e[15:0]};
      arm();
      wr(8'h50, 32'h100 | 32'(e[43:42]));
      rd(8'h50, v); chk(v[31], "R3 busy after start", 64'(v), 64'h8000_0000);
      wait_idle();
      chk(rcount == 64 && !mdc_o, "R3 busy until last edge", 64'(rcount), 64'd64);
      ef = exp_frame(e[44], e[43:42], e[41:37], e[36:32], e[31:16]);
      if (isr) begin
        chk((cap & RD_MASK) == (ef & RD_MASK), "R4 R5 R6 read frame", cap, ef);
        chk(capoe == RD_MASK, "R8 release pattern", capoe, RD_MASK);
        last_rd = e[15:0];
      end else begin
        chk(cap == ef, "R4 R5 R6 R7 drive frame", cap, ef);
        chk(capoe == '1, "R7 drive enable", capoe, '1);
      end
      rd(8'h4C, v); chk(v == 32'(last_rd), "R8 R9 captured data", 64'(v), 64'(last_rd));
      rd(8'h40, v); chk(v == mv, "R1 mode other bits", 64'(v), 64'(mv));
      chk(pmin == 2*HALF && pmax == 2*HALF, "R12 MDC period", 64'(pmax), 64'(2*HALF));
    end

    // R10: start while busy
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h0000_0205);
    wr(8'h48, 32'h0000_BEEF);
    arm();
    wr(8'h50, 32'h101);
    repeat (20) @(negedge clk);
    wr(8'h44, 32'h0000_1F1F);
    wr(8'h50, 32'h100);
    wait_idle();
    ef = exp_frame(1'b0, 2'd1, 5'h02, 5'h05, 16'hBEEF);
    chk(cap == ef, "R10 frame unchanged", cap, ef);
    repeat (300) @(negedge clk);
    chk(rcount == 64, "R10 no extra frame", 64'(rcount), 64'd64);
    rd(8'h4C, v); chk(v == 32'(last_rd), "R9 capture kept after ignored read", 64'(v), 64'(last_rd));

    // R11: non-starting commands
    arm();
    wr(8'h50, 32'h102);
    wr(8'h50, 32'h103);
    wr(8'h50, 32'h001);
    wr(8'h40, 32'h100);
    wr(8'h50, 32'h103);
    repeat (50) @(negedge clk);
    rd(8'h50, v);
    chk(!v[31] && rcount == 0, "R11 nothing started", 64'(rcount), 64'd0);
    chk(!mdc_o && !mdio_oe_o, "R12 idle MDC low", {62'b0, mdc_o, mdio_oe_o}, 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule